// File: doc/BRIEF.md
# EDH Error Flag Port

This block sits beside an error detection and handling (EDH) processor and puts every error flag on five dedicated lines, so a board can read or force the flags without any microcontroller. A 2-bit group select picks which flag group the lines carry. The full-field group is 00, the active-picture group is 01, the ancillary group is 10 and a status group is 11. A direction input chooses between reading the flags and writing them.

Flags written through the port override the host-interface overrides and the processor's own flags. They apply to exactly one outgoing EDH packet and are then released. The packet emitter marks each packet with `pkt_busy`. A write made while a packet is going out is held back and applies to the packet after it. In flag-mapping mode the block drives both the flag lines and the select lines. It steps the select through the four groups while a packet goes out, so a second device in write mode can copy the flags. Between packets it rests on the ancillary group.

The flag vector `pkt_flags` holds eleven bits. Bits 2:0, 5:3 and 8:6 are the full-field, active-picture and ancillary groups. Inside each group the top bit is unknown-error-status, the middle bit is error-detected-already and the lowest bit is error-detected-here. Bit 9 is the active-picture CRC valid bit and bit 10 is the full-field CRC valid bit.

Top module: `edh_flag_port`

## Requirements
- R1: After a synchronous active-low reset no port write is pending, so `pkt_flags` equals the host/core merge. The mapping step counter restarts at 00.
- R2: In read mode (`dir_rd`=1, `map_en`=0), for select 00/01/10 `fl_out` is {UES, IDA, IDH, 0, 0} of the chosen group. Line 4 carries UES and lines 1:0 are zero. The lines follow `sel_in` and `pkt_flags` in the same cycle.
- R3: In read mode with select 11, line 4 carries `io_mode`, line 3 carries bit 9 (AP CRC valid), line 2 carries bit 10 (FF CRC valid), and lines 1:0 are zero.
- R4: In write mode (`dir_rd`=0, `map_en`=0) `fl_oe` and `sel_oe` are low. A cycle with `wr_stb` high loads lines 4:2 into the selected group, and the new flags show on `pkt_flags` from the next cycle.
- R5: A write to group 11 sets bit 9 from line 3 and bit 10 from line 2. Line 4 (the in/out bit) and lines 1:0 are ignored, and all other flags are untouched.
- R6: For each flag bit, a pending port write wins over a host override (`host_msk` bit set, value from `host_val`), and a host override wins over `core_flags`.
- R7: A port write made while `pkt_busy` is low stays in force through the next packet. It is released at the clock edge that first samples `pkt_busy` low after it was high.
- R8: A port write made while `pkt_busy` is high leaves `pkt_flags` unchanged during that packet. It takes effect at that packet's release edge and is released after the following packet.
- R9: `wr_stb` has no effect while `dir_rd` is high or `map_en` is high.
- R10: In mapping mode `fl_oe` and `sel_oe` are high. While `pkt_busy` is high, `sel_out` runs 00, 01, 10, 11 and repeats, starting at 00 on the first busy cycle, and `fl_out` carries the group named by `sel_out`.
- R11: In mapping mode with `pkt_busy` low, `sel_out` is 10 and `fl_out` carries the ancillary group.
- R12: `map_en` may only rise in a cycle whose previous cycle had `dir_rd` high.
- R13: In read mode `fl_oe` is high and `sel_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_rd | input | 1 | 1 = read (port drives), 0 = write (port listens) |
| map_en | input | 1 | Flag-mapping mode |
| wr_stb | input | 1 | Capture the flag lines in write mode |
| sel_in | input | 2 | Group select from the board |
| fl_in | input | 5 | Flag lines, input side |
| pkt_busy | input | 1 | High while an outgoing EDH packet is emitted |
| core_flags | input | 11 | Flags from the EDH processor |
| host_msk | input | 11 | Host override enables |
| host_val | input | 11 | Host override values |
| io_mode | input | 1 | In/out indicator shown in group 11 |
| fl_out | output | 5 | Flag lines, output side |
| fl_oe | output | 1 | Flag line output enable |
| sel_out | output | 2 | Select lines driven in mapping mode |
| sel_oe | output | 1 | Select line output enable |
| pkt_flags | output | 11 | Flags for the outgoing packet |

## Verification
Several properties are checked on every cycle. The pending-write set must stay frozen during a packet, and the staged write must move into force at the release edge. A direct write must land on `pkt_flags` one cycle later. Mapping mode must step the select by one per busy cycle, `map_en` must rise only after a read-mode cycle, and the select output enable must imply the flag output enable. Other behaviours only show in the bench's scenarios: the exact line layout of each group, the ignored in/out bit, the three-level priority, writes blocked by direction or mapping, and the two-packet life of a write made during emission.

// File: rtl/edh_fp_pkg.sv
// Package: shared sizes, flag vector type and group coding helpers for the
// EDH flag port. Assumes three 3-flag error groups plus two CRC valid bits.
package edh_fp_pkg;
    localparam int LINES    = 5;
    localparam int GRP_W    = 2;
    localparam int FPG      = 3;
    localparam int NGRP     = 3;
    localparam int NFLAG    = NGRP * FPG + 2;
    localparam int APV_IDX  = NGRP * FPG;
    localparam int FFV_IDX  = NGRP * FPG + 1;
    localparam int LO_LINE  = LINES - FPG;
    localparam logic [GRP_W-1:0] SEL_ANC  = 2'd2;
    localparam logic [GRP_W-1:0] SEL_STAT = 2'd3;

    typedef logic [NFLAG-1:0] flag_vec_t;
    typedef logic [LINES-1:0] line_t;

    // Flags touched by a write to group g.
    function automatic flag_vec_t grp_mask(input logic [GRP_W-1:0] g);
        flag_vec_t m;
        m = '0;
        if (g == SEL_STAT) begin
            m[APV_IDX] = 1'b1;
            m[FFV_IDX] = 1'b1;
        end else begin
            for (int i = 0; i < FPG; i++) m[int'(g) * FPG + i] = 1'b1;
        end
        return m;
    endfunction

    // Flag values carried by the lines for a write to group g.
    function automatic flag_vec_t grp_value(input logic [GRP_W-1:0] g, input line_t ln);
        flag_vec_t v;
        v = '0;
        if (g == SEL_STAT) begin
            v[APV_IDX] = ln[3];
            v[FFV_IDX] = ln[2];
        end else begin
            for (int i = 0; i < FPG; i++) v[int'(g) * FPG + i] = ln[LO_LINE + i];
        end
        return v;
    endfunction

    // Line word presented for group g.
    function automatic line_t rd_word(input logic [GRP_W-1:0] g, input flag_vec_t f,
                                      input logic io);
        line_t w;
        w = '0;
        if (g == SEL_STAT) begin
            w[4] = io;
            w[3] = f[APV_IDX];
            w[2] = f[FFV_IDX];
        end else begin
            for (int i = 0; i < FPG; i++) w[LO_LINE + i] = f[int'(g) * FPG + i];
        end
        return w;
    endfunction
endpackage

// File: rtl/edh_fp_latch.sv
// Module: one-shot write store. Holds the flags written through the port for
// exactly one packet; writes during a packet are staged for the next one.
// Assumes wr_en is already qualified by direction and mapping mode.
module edh_fp_latch
    import edh_fp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_busy,
    input  logic             wr_en,
    input  logic [GRP_W-1:0] wr_grp,
    input  line_t            wr_lines,
    output flag_vec_t        act_val,
    output flag_vec_t        act_msk
);
    flag_vec_t stg_val, stg_msk;
    flag_vec_t nx_av, nx_am, nx_sv, nx_sm;
    flag_vec_t wm, wv, wm_act, wm_stg;
    logic      busy_q, rel;

    // Next-state of the active and staged write sets.
    always_comb begin
        rel    = busy_q & ~pkt_busy;
        wm     = wr_en ? grp_mask(wr_grp) : '0;
        wv     = grp_value(wr_grp, wr_lines);
        wm_act = pkt_busy ? '0 : wm;
        wm_stg = pkt_busy ? wm : '0;
        nx_av  = rel ? stg_val : act_val;
        nx_am  = rel ? stg_msk : act_msk;
        nx_sv  = rel ? '0 : stg_val;
        nx_sm  = rel ? '0 : stg_msk;
        nx_av  = (nx_av & ~wm_act) | (wv & wm_act);
        nx_am  = nx_am | wm_act;
        nx_sv  = (nx_sv & ~wm_stg) | (wv & wm_stg);
        nx_sm  = nx_sm | wm_stg;
    end

    // Register the write sets and the packet-busy history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_val <= '0;
            act_msk <= '0;
            stg_val <= '0;
            stg_msk <= '0;
            busy_q  <= 1'b0;
        end else begin
            act_val <= nx_av;
            act_msk <= nx_am;
            stg_val <= nx_sv;
            stg_msk <= nx_sm;
            busy_q  <= pkt_busy;
        end
    end

    // R7: the set in force does not move while a packet is out
    a_r7_frozen_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> ($stable(act_msk) && $stable(act_val)));

    // R8: at the release edge the staged set becomes the set in force
    a_r8_stage_promotes: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !pkt_busy && !wr_en) |=> (act_msk == $past(stg_msk)));
endmodule

// File: rtl/edh_fp_merge.sv
// Module: per-flag priority merge: port write, then host override, then core.
// Purely combinational; assumes all inputs are in the pixel clock domain.
module edh_fp_merge
    import edh_fp_pkg::*;
(
    input  flag_vec_t port_val,
    input  flag_vec_t port_msk,
    input  flag_vec_t host_val,
    input  flag_vec_t host_msk,
    input  flag_vec_t core_flags,
    output flag_vec_t pkt_flags
);
    // One priority mux per flag bit.
    for (genvar i = 0; i < NFLAG; i++) begin : g_bit
        assign pkt_flags[i] = port_msk[i] ? port_val[i]
                            : (host_msk[i] ? host_val[i] : core_flags[i]);
    end
endmodule

// File: rtl/edh_fp_mapper.sv
// Module: line driver and mapping sequencer. Picks the group shown on the
// flag lines, steps the select in mapping mode and sets the output enables.
module edh_fp_mapper
    import edh_fp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_rd,
    input  logic             map_en,
    input  logic             pkt_busy,
    input  logic [GRP_W-1:0] sel_in,
    input  flag_vec_t        pkt_flags,
    input  logic             io_mode,
    output line_t            fl_out,
    output logic             fl_oe,
    output logic [GRP_W-1:0] sel_out,
    output logic             sel_oe
);
    logic [GRP_W-1:0] step_q, eff_sel;
    logic             stepping;

    assign stepping = map_en & pkt_busy;

    // Step counter: runs while mapping a packet, restarts otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        step_q <= '0;
        else if (stepping) step_q <= step_q + GRP_W'(1);
        else               step_q <= '0;
    end

    // Select, line word and enables.
    always_comb begin
        sel_out = stepping ? step_q : SEL_ANC;
        eff_sel = map_en ? sel_out : sel_in;
        fl_out  = rd_word(eff_sel, pkt_flags, io_mode);
        fl_oe   = dir_rd | map_en;
        sel_oe  = map_en;
    end

    // R10: each busy mapping cycle advances the select by one
    a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
        (map_en && pkt_busy && $past(map_en) && $past(pkt_busy))
            |-> (sel_out == $past(sel_out) + 2'd1));
endmodule

// File: rtl/edh_flag_port.sv
// Module: top of the EDH flag port. Qualifies port writes, keeps them for one
// packet, merges them over host and core flags and drives the lines.
// Assumes the packet emitter holds pkt_busy high for a whole packet.
module edh_flag_port
    import edh_fp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dir_rd,
    input  logic        map_en,
    input  logic        wr_stb,
    input  logic [1:0]  sel_in,
    input  logic [4:0]  fl_in,
    input  logic        pkt_busy,
    input  logic [10:0] core_flags,
    input  logic [10:0] host_msk,
    input  logic [10:0] host_val,
    input  logic        io_mode,
    output logic [4:0]  fl_out,
    output logic        fl_oe,
    output logic [1:0]  sel_out,
    output logic        sel_oe,
    output logic [10:0] pkt_flags
);
    flag_vec_t act_val, act_msk;
    logic      wr_ok;
    logic      unused_low_lines;

    assign wr_ok            = wr_stb & ~dir_rd & ~map_en;
    assign unused_low_lines = ^fl_in[1:0];

    edh_fp_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_busy (pkt_busy),
        .wr_en    (wr_ok),
        .wr_grp   (sel_in),
        .wr_lines (fl_in),
        .act_val  (act_val),
        .act_msk  (act_msk)
    );

    edh_fp_merge u_merge (
        .port_val   (act_val),
        .port_msk   (act_msk),
        .host_val   (host_val),
        .host_msk   (host_msk),
        .core_flags (core_flags),
        .pkt_flags  (pkt_flags)
    );

    edh_fp_mapper u_mapper (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_rd    (dir_rd),
        .map_en    (map_en),
        .pkt_busy  (pkt_busy),
        .sel_in    (sel_in),
        .pkt_flags (pkt_flags),
        .io_mode   (io_mode),
        .fl_out    (fl_out),
        .fl_oe     (fl_oe),
        .sel_out   (sel_out),
        .sel_oe    (sel_oe)
    );

    // R4 and R6: an idle-time write reaches the packet flags on the next cycle
    a_r6_port_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !pkt_busy)
            |=> (((pkt_flags ^ $past(grp_value(sel_in, fl_in))) & $past(grp_mask(sel_in))) == '0));

    // R12: mapping mode is entered only after a read-mode cycle
    a_r12_map_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(map_en) |-> $past(dir_rd));

    // R13: select lines are never driven without the flag lines
    a_r13_oe_pair: assert property (@(posedge clk) disable iff (!rst_n)
        sel_oe |-> fl_oe);
endmodule

// File: tb/edh_flag_port_bench.sv
module edh_flag_port_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_rd, map_en, wr_stb, pkt_busy, io_mode;
    logic [1:0]  sel_in;
    logic [4:0]  fl_in;
    logic [10:0] core_flags, host_msk, host_val;
    logic [4:0]  fl_out;
    logic        fl_oe, sel_oe;
    logic [1:0]  sel_out;
    logic [10:0] pkt_flags;

    int n_chk = 0, n_fail = 0;
    logic [10:0] m_av, m_am, m_sv, m_sm;
    logic        m_busy_q;
    logic [1:0]  m_cnt;

    always #(CLK_P/2) clk = ~clk;

    edh_flag_port u_edh_flag_port (
        .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .map_en(map_en), .wr_stb(wr_stb),
        .sel_in(sel_in), .fl_in(fl_in), .pkt_busy(pkt_busy), .core_flags(core_flags),
        .host_msk(host_msk), .host_val(host_val), .io_mode(io_mode), .fl_out(fl_out),
        .fl_oe(fl_oe), .sel_out(sel_out), .sel_oe(sel_oe), .pkt_flags(pkt_flags)
    );

    function automatic logic [10:0] b_mask(input logic [1:0] g);
        case (g)
            2'd0: return 11'h007;
            2'd1: return 11'h038;
            2'd2: return 11'h1C0;
            default: return 11'h600;
        endcase
    endfunction

    function automatic logic [10:0] b_value(input logic [1:0] g, input logic [4:0] l);
        case (g)
            2'd0: return {8'b0, l[4:2]};
            2'd1: return {5'b0, l[4:2], 3'b0};
            2'd2: return {2'b0, l[4:2], 6'b0};
            default: return {l[2], l[3], 9'b0};
        endcase
    endfunction

    function automatic logic [4:0] b_word(input logic [1:0] g, input logic [10:0] f, input logic io);
        case (g)
            2'd0: return {f[2], f[1], f[0], 2'b00};
            2'd1: return {f[5], f[4], f[3], 2'b00};
            2'd2: return {f[8], f[7], f[6], 2'b00};
            default: return {io, f[9], f[10], 2'b00};
        endcase
    endfunction

    function automatic logic [10:0] b_flags();
        return (m_am & m_av) | (~m_am & host_msk & host_val) | (~m_am & ~host_msk & core_flags);
    endfunction

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [1:0] esel;
        esel = (map_en && pkt_busy) ? m_cnt : 2'd2;
        check(req, "pkt_flags", 16'(pkt_flags), 16'(b_flags()));
        check(req, "fl_oe", 16'(fl_oe), 16'(dir_rd | map_en));
        check(req, "sel_oe", 16'(sel_oe), 16'(map_en));
        if (map_en) check(req, "sel_out", 16'(sel_out), 16'(esel));
        if (dir_rd || map_en)
            check(req, "fl_out", 16'(fl_out), 16'(b_word(map_en ? esel : sel_in, b_flags(), io_mode)));
    endtask

    task automatic model_update();
        logic rel, wr;
        logic [10:0] wm, wv, na_v, na_m, ns_v, ns_m;
        if (!rst_n) begin
            m_av = '0; m_am = '0; m_sv = '0; m_sm = '0; m_busy_q = 1'b0; m_cnt = '0;
            return;
        end
        rel  = m_busy_q && !pkt_busy;
        wr   = wr_stb && !dir_rd && !map_en;
        wm   = wr ? b_mask(sel_in) : '0;
        wv   = b_value(sel_in, fl_in);
        na_v = rel ? m_sv : m_av;  na_m = rel ? m_sm : m_am;
        ns_v = rel ? '0 : m_sv;    ns_m = rel ? '0 : m_sm;
        if (pkt_busy) begin ns_v = (ns_v & ~wm) | (wv & wm); ns_m = ns_m | wm; end
        else          begin na_v = (na_v & ~wm) | (wv & wm); na_m = na_m | wm; end
        m_av = na_v; m_am = na_m; m_sv = ns_v; m_sm = ns_m;
        m_cnt = (pkt_busy && map_en) ? m_cnt + 2'd1 : 2'd0;
        m_busy_q = pkt_busy;
    endtask

    task automatic cycle();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20931));
        dir_rd = 0; map_en = 0; wr_stb = 0; pkt_busy = 0; io_mode = 1; sel_in = 0; fl_in = 0;
        core_flags = 11'b10_110_011_101; host_msk = 0; host_val = 0;
        repeat (3) cycle();
        rst_n = 1'b1;
        #1;
        // R1: nothing pending after reset
        check("R1", "pkt_flags after reset", 16'(pkt_flags), 16'(core_flags));
        check_all("R1");

        // R2, R3, R13: read decoding
        dir_rd = 1;
        for (int g = 0; g < 4; g++) begin
            sel_in = 2'(g);
            #1;
            case (g)
                0: check("R2", "ff word", 16'(fl_out), 16'(5'b10100));
                1: check("R2", "ap word", 16'(fl_out), 16'(5'b01100));
                2: check("R2", "anc word", 16'(fl_out), 16'(5'b11000));
                default: check("R3", "status word", 16'(fl_out), 16'(5'b10100));
            endcase
            check_all("R13");
        end
        cycle();

        // R4: write active-picture group
        dir_rd = 0; sel_in = 1; fl_in = 5'b10011; wr_stb = 1;
        #1 check_all("R4");
        cycle();
        wr_stb = 0; fl_in = 0;
        #1 check("R4", "ap after write", 16'(pkt_flags[5:3]), 16'(3'b100));

        // R6: priority over host
        host_msk = 11'h03F; host_val = 11'b00000_010_111;
        #1 check("R6", "ap port wins", 16'(pkt_flags[5:3]), 16'(3'b100));
        check("R6", "ff host wins", 16'(pkt_flags[2:0]), 16'(3'b111));
        check_all("R6");

        // R7: one packet then release
        pkt_busy = 1;
        repeat (3) begin cycle(); #1 check("R7", "ap held in packet", 16'(pkt_flags[5:3]), 16'(3'b100)); end
        pkt_busy = 0;
        #1 check("R7", "ap before release", 16'(pkt_flags[5:3]), 16'(3'b100));
        cycle();
        #1 check("R7", "ap released", 16'(pkt_flags[5:3]), 16'(3'b010));

        // R8: write during a packet is staged
        pkt_busy = 1; cycle();
        sel_in = 0; fl_in = 5'b00000; wr_stb = 1; cycle();
        wr_stb = 0;
        #1 check("R8", "ff unchanged in packet", 16'(pkt_flags[2:0]), 16'(3'b111));
        cycle(); pkt_busy = 0; cycle();
        #1 check("R8", "ff staged applied", 16'(pkt_flags[2:0]), 16'(3'b000));
        pkt_busy = 1; repeat (2) cycle();
        #1 check("R8", "ff kept in next packet", 16'(pkt_flags[2:0]), 16'(3'b000));
        pkt_busy = 0; cycle();
        #1 check("R8", "ff released", 16'(pkt_flags[2:0]), 16'(3'b111));
        check_all("R8");

        // R5: status group write
        sel_in = 3; fl_in = 5'b11011; wr_stb = 1; cycle();
        wr_stb = 0;
        #1 check("R5", "apv", 16'(pkt_flags[9]), 16'(1'b1));
        check("R5", "ffv", 16'(pkt_flags[10]), 16'(1'b0));
        check("R5", "others", 16'(pkt_flags[8:0]), 16'(b_flags() & 11'h1FF));
        check_all("R5");
        dir_rd = 1; io_mode = 0;
        #1 check("R5", "in/out follows io_mode", 16'(fl_out[4]), 16'(1'b0));
        pkt_busy = 1; cycle(); pkt_busy = 0; cycle();

        // R9: writes blocked in read mode
        sel_in = 2; fl_in = 5'b11100; wr_stb = 1; cycle();
        wr_stb = 0;
        #1 check("R9", "anc not written", 16'(pkt_flags[8:6]), 16'(3'b110));

        // R10, R11: mapping mode
        map_en = 1;
        #1 check("R11", "rest select", 16'(sel_out), 16'(2'd2));
        check("R11", "rest word", 16'(fl_out), 16'(5'b11000));
        cycle();
        pkt_busy = 1;
        #1 check("R10", "first step", 16'(sel_out), 16'(2'd0));
        for (int k = 0; k < 5; k++) begin
            cycle();
            #1 check("R10", "step", 16'(sel_out), 16'((k + 1) % 4));
            check_all("R10");
        end
        pkt_busy = 0;
        cycle();
        #1 check_all("R11");
        map_en = 0; cycle();

        // random phase
        for (int n = 0; n < 3000; n++) begin
            if (map_en) begin
                if ($urandom % 16 == 0) map_en = 0;
            end else if (dir_rd && ($urandom % 8 == 0)) map_en = 1;
            dir_rd = map_en ? 1'b1 : 1'($urandom % 2);
            if ($urandom % 6 == 0) pkt_busy = ~pkt_busy;
            wr_stb = ($urandom % 3 == 0);
            sel_in = 2'($urandom);
            fl_in  = 5'($urandom);
            io_mode = 1'($urandom);
            if ($urandom % 4 == 0) core_flags = 11'($urandom);
            if ($urandom % 16 == 0) begin host_msk = 11'($urandom); host_val = 11'($urandom); end
            #1 check_all("R2,R4,R6,R7,R8,R10 random");
            cycle();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule